// File: doc/BRIEF.md
# Register-Controlled Pin Mux and GPIO Block

This block controls a bank of general-purpose pins through a small word-addressed register bus. For every pin it produces an output level, an output enable and an open-drain flag. Software owns the pins through a set of control words: a data word, a drive-enable word, an open-drain word and four source-select words. Each pin carries two 2-bit source fields. One picks where the pin's output level comes from and the other picks where its enable comes from. The choices are the software-written GPIO words or one of three alternate-function sources. The alternate-function logic sits outside the block.

Pin numbering runs from the most significant bit down. Pin n sits at bit (NPINS-1-n) of every one-bit-per-pin word. Pins in the first half of the bank take their 2-bit fields from the "low" select words, and pins in the second half take them from the "high" select words. Within either word the field for the first pin of that half occupies the top two bits. Incoming pin levels are resynchronized through a two-flop chain. The resynchronized levels can be read back in a level word that uses the same bit order.

The bus has no ready signal. Every request is accepted in the cycle where `bus_valid` is high, so the block never applies back-pressure. A read returns its word one cycle later, with `bus_rvalid` high for that one cycle. The requester must take the response in that cycle, because there is no holding or stalling.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset, every register word reads 0, and `pin_out`, `pin_oe` and `pin_od` are all 0, so every pin floats as a GPIO input.
- R2: A write with `bus_valid`=1 and `bus_write`=1 takes effect at that clock edge. A read with `bus_valid`=1 and `bus_write`=0 presents the word on `bus_rdata` with `bus_rvalid`=1 in the following cycle. Words 0 to 6 read back what was last written to them.
- R3: Pin n uses bit (NPINS-1-n) of word 0 (data), word 1 (drive), word 6 (open-drain) and word 7 (level), so pin 0 is the MSB.
- R4: When a pin's enable field is 00, `pin_oe` for that pin equals its drive bit in word 1: 1 drives the pin and 0 floats it.
- R5: The 2-bit field for pin n sits at bits [NPINS-1-2k : NPINS-2-2k], where k = n mod (NPINS/2). Level fields are in word 2 (pins below NPINS/2) or word 3 (the rest). Enable fields are in word 4 or word 5 with the same split.
- R6: A field value of 00 selects the GPIO source. Values 01, 10 and 11 select alternate sources 1, 2 and 3 for that pin. Level fields and enable fields are chosen independently.
- R7: With the pin's open-drain bit set in word 6, `pin_od`=1 and `pin_out`=0. `pin_oe` is then 1 only when the selected enable is 1 and the selected level is 0.
- R8: Word 7 returns the pin inputs through a two-flop synchronizer. A change on `pin_in` applied before edge k is returned by a read requested at edge k+2 or later, and not by a read requested at edge k or k+1.
- R9: Writes to word 7 are ignored, and the word keeps reporting the pin levels.
- R10: Words 8 to 17 store and read back written values, and writing them has no effect on any pin output.
- R11: Addresses 18 and above read as 0, and writes to them change nothing.
- R12: A write to a control word changes the pin outputs from the cycle right after its write edge, because the pin outputs are a combinational function of the registers and the alternate inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request present, always accepted |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response, one cycle after a read request |
| pin_in | input | NPINS | Asynchronous pin levels, index = pin number |
| alt1_val | input | NPINS | Alternate source 1 level per pin |
| alt1_en | input | NPINS | Alternate source 1 enable per pin |
| alt2_val | input | NPINS | Alternate source 2 level per pin |
| alt2_en | input | NPINS | Alternate source 2 enable per pin |
| alt3_val | input | NPINS | Alternate source 3 level per pin |
| alt3_en | input | NPINS | Alternate source 3 enable per pin |
| pin_out | output | NPINS | Output level per pin |
| pin_oe | output | NPINS | Output enable per pin |
| pin_od | output | NPINS | Open-drain mode per pin |

## Verification
On every cycle, the assertions check the reset floating state, the one-cycle read response timing, and the open-drain rule that a pin in that mode never drives a 1. They also check the three-edge path from a pin level to the read data, and that unmapped addresses read zero. Other behaviour can only be shown by the bench's scenarios, because the expected values depend on register contents the bench wrote earlier. These cases are the selection of level and enable sources across all field combinations, the placement of each pin's field in the low or high word, the MSB-first bit order, and the absence of side effects from writes to the spare and level words.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

  // Word map; offsets are decoded by software so they are fixed.
  localparam int unsigned WORD_DATA    = 0;
  localparam int unsigned WORD_DRIVE   = 1;
  localparam int unsigned WORD_VSEL_LO = 2;
  localparam int unsigned WORD_VSEL_HI = 3;
  localparam int unsigned WORD_ESEL_LO = 4;
  localparam int unsigned WORD_ESEL_HI = 5;
  localparam int unsigned WORD_ODRAIN  = 6;
  localparam int unsigned WORD_LEVEL   = 7;
  localparam int unsigned CTL_WORDS    = 7;
  localparam int unsigned SPARE_BASE   = 8;
  localparam int unsigned WORD_COUNT   = 18;
  localparam int unsigned SPARE_WORDS  = WORD_COUNT - SPARE_BASE;

  localparam int unsigned ALT_SOURCES  = 3;
  localparam int unsigned FIELD_W      = 2;

  typedef enum logic [FIELD_W-1:0] {
    SRC_GPIO = 2'b00,
    SRC_ALT1 = 2'b01,
    SRC_ALT2 = 2'b10,
    SRC_ALT3 = 2'b11
  } src_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPINS-1:0]  level_word,
  output logic [NPINS-1:0]  data_w,
  output logic [NPINS-1:0]  drive_w,
  output logic [NPINS-1:0]  vsel_lo_w,
  output logic [NPINS-1:0]  vsel_hi_w,
  output logic [NPINS-1:0]  esel_lo_w,
  output logic [NPINS-1:0]  esel_hi_w,
  output logic [NPINS-1:0]  odrain_w
);

  logic [NPINS-1:0] ctl_q   [CTL_WORDS];
  logic [NPINS-1:0] spare_q [SPARE_WORDS];
  logic [NPINS-1:0] view    [WORD_COUNT];
  logic [NPINS-1:0] rd_word;
  logic             wr_en;
  logic             rd_en;

  assign wr_en = bus_valid &  bus_write;
  assign rd_en = bus_valid & ~bus_write;

  // Control words: one flop bank per word, decoded by address compare.
  for (genvar w = 0; w < CTL_WORDS; w++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (!rst_n)
        ctl_q[w] <= '0;
      else if (wr_en && bus_addr == ADDR_W'(w))
        ctl_q[w] <= bus_wdata;
    end
    assign view[w] = ctl_q[w];
  end

  // Level word is read-only; writes fall through the decode.
  assign view[WORD_LEVEL] = level_word;

  // Spare words: stored, readable, wired to nothing else.
  for (genvar s = 0; s < SPARE_WORDS; s++) begin : g_spare
    always_ff @(posedge clk) begin
      if (!rst_n)
        spare_q[s] <= '0;
      else if (wr_en && bus_addr == ADDR_W'(SPARE_BASE + s))
        spare_q[s] <= bus_wdata;
    end
    assign view[SPARE_BASE + s] = spare_q[s];
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORD_COUNT; w++) begin
      if (bus_addr == ADDR_W'(w)) rd_word = view[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_word;
    end
  end

  assign data_w    = ctl_q[WORD_DATA];
  assign drive_w   = ctl_q[WORD_DRIVE];
  assign vsel_lo_w = ctl_q[WORD_VSEL_LO];
  assign vsel_hi_w = ctl_q[WORD_VSEL_HI];
  assign esel_lo_w = ctl_q[WORD_ESEL_LO];
  assign esel_hi_w = ctl_q[WORD_ESEL_HI];
  assign odrain_w  = ctl_q[WORD_ODRAIN];

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0]                  data_w,
  input  logic [NPINS-1:0]                  drive_w,
  input  logic [NPINS-1:0]                  vsel_lo_w,
  input  logic [NPINS-1:0]                  vsel_hi_w,
  input  logic [NPINS-1:0]                  esel_lo_w,
  input  logic [NPINS-1:0]                  esel_hi_w,
  input  logic [NPINS-1:0]                  odrain_w,
  input  logic [ALT_SOURCES-1:0][NPINS-1:0] alt_val,
  input  logic [ALT_SOURCES-1:0][NPINS-1:0] alt_en,
  output logic [NPINS-1:0]                  pin_out,
  output logic [NPINS-1:0]                  pin_oe,
  output logic [NPINS-1:0]                  pin_od
);

  localparam int unsigned HALF = NPINS / 2;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    localparam int unsigned RB = NPINS - 1 - n;
    localparam int unsigned FB = NPINS - 1 - FIELD_W * (n % HALF);

    src_sel_e               vsel;
    src_sel_e               esel;
    logic [ALT_SOURCES:0]   val_opts;
    logic [ALT_SOURCES:0]   en_opts;
    logic                   val;
    logic                   en;
    logic                   od;

    if (n < HALF) begin : g_lo
      assign vsel = src_sel_e'(vsel_lo_w[FB -: FIELD_W]);
      assign esel = src_sel_e'(esel_lo_w[FB -: FIELD_W]);
    end else begin : g_hi
      assign vsel = src_sel_e'(vsel_hi_w[FB -: FIELD_W]);
      assign esel = src_sel_e'(esel_hi_w[FB -: FIELD_W]);
    end

    assign val_opts[0] = data_w[RB];
    assign en_opts[0]  = drive_w[RB];
    for (genvar a = 0; a < ALT_SOURCES; a++) begin : g_alt
      assign val_opts[a+1] = alt_val[a][n];
      assign en_opts[a+1]  = alt_en[a][n];
    end

    assign val = val_opts[vsel];
    assign en  = en_opts[esel];
    assign od  = odrain_w[RB];

    // Open-drain: only ever pull low; a 1 releases the pin.
    assign pin_od[n]  = od;
    assign pin_out[n] = val & ~od;
    assign pin_oe[n]  = od ? (en & ~val) : en;
  end

endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  alt1_val,
  input  logic [NPINS-1:0]  alt1_en,
  input  logic [NPINS-1:0]  alt2_val,
  input  logic [NPINS-1:0]  alt2_en,
  input  logic [NPINS-1:0]  alt3_val,
  input  logic [NPINS-1:0]  alt3_en,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_od
);

  logic [NPINS-1:0] synced;
  logic [NPINS-1:0] level_word;
  logic [NPINS-1:0] data_w, drive_w, odrain_w;
  logic [NPINS-1:0] vsel_lo_w, vsel_hi_w, esel_lo_w, esel_hi_w;
  logic [ALT_SOURCES-1:0][NPINS-1:0] alt_val;
  logic [ALT_SOURCES-1:0][NPINS-1:0] alt_en;

  assign alt_val = {alt3_val, alt2_val, alt1_val};
  assign alt_en  = {alt3_en,  alt2_en,  alt1_en};

  gpio_in_sync #(
    .WIDTH  (NPINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (synced)
  );

  // Pin n lands on the word bit NPINS-1-n.
  for (genvar n = 0; n < NPINS; n++) begin : g_rev
    assign level_word[NPINS-1-n] = synced[n];
  end

  gpio_regfile #(
    .NPINS  (NPINS),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .level_word (level_word),
    .data_w     (data_w),
    .drive_w    (drive_w),
    .vsel_lo_w  (vsel_lo_w),
    .vsel_hi_w  (vsel_hi_w),
    .esel_lo_w  (esel_lo_w),
    .esel_hi_w  (esel_hi_w),
    .odrain_w   (odrain_w)
  );

  gpio_pin_mux #(
    .NPINS (NPINS)
  ) u_mux (
    .data_w    (data_w),
    .drive_w   (drive_w),
    .vsel_lo_w (vsel_lo_w),
    .vsel_hi_w (vsel_hi_w),
    .esel_lo_w (esel_lo_w),
    .esel_hi_w (esel_hi_w),
    .odrain_w  (odrain_w),
    .alt_val   (alt_val),
    .alt_en    (alt_en),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od)
  );

endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
  import gpio_mux_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pin_od
);

  function automatic logic [NPINS-1:0] flip(input logic [NPINS-1:0] v);
    logic [NPINS-1:0] r;
    for (int i = 0; i < NPINS; i++) r[NPINS-1-i] = v[i];
    return r;
  endfunction

  // Cycles since reset release, saturating, to bound the $past window.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_reset_floats_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_od == '0 && bus_rvalid == 1'b0));

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_no_write_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_od & pin_out) == '0));

  assert_level_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && bus_valid && !bus_write && bus_addr == ADDR_W'(WORD_LEVEL))
    |=> bus_rdata == flip($past(pin_in, 3)));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr >= ADDR_W'(WORD_COUNT)) |=> bus_rdata == '0);

endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk #(
  .NPINS  (NPINS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .pin_od     (pin_od)
);

// File: tb/test_gpio_mux_ctrl.sv
`timescale 1ns/1ps
module test_gpio_mux_ctrl;

  localparam int NP = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic          bus_rvalid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] a1v = '0, a1e = '0, a2v = '0, a2e = '0, a3v = '0, a3e = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_od;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench copy of the software-visible control words
  logic [NP-1:0] m_data, m_drive, m_vlo, m_vhi, m_elo, m_ehi, m_od;

  always #2 clk = ~clk;

  gpio_mux_ctrl i_gpio_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in),
    .alt1_val(a1v), .alt1_en(a1e), .alt2_val(a2v), .alt2_en(a2e),
    .alt3_val(a3v), .alt3_en(a3e),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od));

  task automatic chk(input bit ok, input string req,
                     input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [NP-1:0] flip(input logic [NP-1:0] v);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[NP-1-i] = v[i];
    return r;
  endfunction

  // Tasks are entered and left at a falling edge.
  task automatic wr(input int a, input logic [NP-1:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input int a, output logic [NP-1:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = AW'(a);
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
    chk(bus_rvalid === 1'b1, "R2 rvalid", {31'd0, bus_rvalid}, 1);
  endtask

  task automatic set_ctl(input logic [NP-1:0] d, dr, vlo, vhi, elo, ehi, od);
    m_data = d; m_drive = dr; m_vlo = vlo; m_vhi = vhi; m_elo = elo; m_ehi = ehi; m_od = od;
    wr(0, d); wr(1, dr); wr(2, vlo); wr(3, vhi); wr(4, elo); wr(5, ehi); wr(6, od);
  endtask

  function automatic logic [1:0] field(input logic [NP-1:0] lo, input logic [NP-1:0] hi, input int n);
    if (n < NP/2) return lo[NP-1-2*n -: 2];
    return hi[NP-1-2*(n-NP/2) -: 2];
  endfunction

  // Build a select word for one half from a per-pin code rule.
  function automatic logic [NP-1:0] mk_sel(input int half, input int mode);
    logic [NP-1:0] w = '0;
    for (int k = 0; k < NP/2; k++) begin
      int n = k + half*NP/2;
      int c = (mode == 0) ? (n % 4) : (mode == 1) ? ((n/4) % 4) : ((n*3 + 1) % 4);
      w[NP-1-2*k -: 2] = 2'(c);
    end
    return w;
  endfunction

  task automatic check_pins(input string req);
    logic [NP-1:0] eo, ee, ed;
    for (int n = 0; n < NP; n++) begin
      logic [1:0] vs = field(m_vlo, m_vhi, n);
      logic [1:0] es = field(m_elo, m_ehi, n);
      logic v = (vs == 0) ? m_data[NP-1-n] : (vs == 1) ? a1v[n] : (vs == 2) ? a2v[n] : a3v[n];
      logic e = (es == 0) ? m_drive[NP-1-n] : (es == 1) ? a1e[n] : (es == 2) ? a2e[n] : a3e[n];
      logic o = m_od[NP-1-n];
      ed[n] = o;
      eo[n] = o ? 1'b0 : v;
      ee[n] = o ? (e & ~v) : e;
    end
    chk(pin_out === eo, {req, " pin_out"}, pin_out, eo);
    chk(pin_oe  === ee, {req, " pin_oe"},  pin_oe,  ee);
    chk(pin_od  === ed, {req, " pin_od"},  pin_od,  ed);
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [NP-1:0] d, snap_o, snap_e, snap_d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(pin_out === '0, "R1 pin_out", pin_out, '0);
    chk(pin_oe  === '0, "R1 pin_oe",  pin_oe,  '0);
    chk(pin_od  === '0, "R1 pin_od",  pin_od,  '0);
    for (int w = 0; w < 18; w++) begin
      rd(w, d);
      chk(d === '0, "R1 word", d, '0);
    end

    // R2: control word readback
    for (int w = 0; w < 7; w++) wr(w, 32'hA5C3_0F96 ^ (32'h0101_0101 * w));
    for (int w = 0; w < 7; w++) begin
      rd(w, d);
      chk(d === (32'hA5C3_0F96 ^ (32'h0101_0101 * w)), "R2 readback", d, 32'hA5C3_0F96 ^ (32'h0101_0101 * w));
    end

    // R3/R4: pure GPIO mode, MSB-first
    a1v = 32'h1234_5678; a1e = 32'hF0F0_3C3C;
    a2v = 32'h9ABC_DEF0; a2e = 32'h0FF0_A55A;
    a3v = 32'hC3A5_5A3C; a3e = 32'h3333_CCCC;
    set_ctl(32'h8000_0001, 32'hC000_0003, '0, '0, '0, '0, '0);
    chk(pin_out === 32'h8000_0001, "R3 data bit order", pin_out, 32'h8000_0001);
    chk(pin_oe  === 32'hC000_0003, "R4 drive bit order", pin_oe, 32'hC000_0003);
    set_ctl(32'h0000_8000, 32'hFFFF_0000, '0, '0, '0, '0, '0);
    chk(pin_out === 32'h0001_0000, "R3 pin16", pin_out, 32'h0001_0000);
    chk(pin_oe  === 32'h0000_FFFF, "R4 low pins driven", pin_oe, 32'h0000_FFFF);

    // R10: spare words store, pins untouched
    snap_o = pin_out; snap_e = pin_oe; snap_d = pin_od;
    for (int w = 8; w < 18; w++) wr(w, ~(32'h0F1E_2D3C + w));
    chk(pin_out === snap_o, "R10 pin_out unchanged", pin_out, snap_o);
    chk(pin_oe  === snap_e, "R10 pin_oe unchanged",  pin_oe,  snap_e);
    chk(pin_od  === snap_d, "R10 pin_od unchanged",  pin_od,  snap_d);
    for (int w = 8; w < 18; w++) begin
      rd(w, d);
      chk(d === ~(32'h0F1E_2D3C + w), "R10 spare readback", d, ~(32'h0F1E_2D3C + w));
    end

    // R11: unmapped addresses
    wr(20, 32'hFFFF_FFFF); wr(31, 32'h1357_9BDF);
    rd(20, d); chk(d === '0, "R11 addr20", d, '0);
    rd(31, d); chk(d === '0, "R11 addr31", d, '0);
    rd(0, d);  chk(d === m_data, "R11 data untouched", d, m_data);
    chk(pin_oe === snap_e, "R11 pins untouched", pin_oe, snap_e);

    // R6/R7/R12: sweep uniform field codes with and without open-drain
    for (int sv = 0; sv < 4; sv++)
      for (int se = 0; se < 4; se++)
        for (int o = 0; o < 2; o++) begin
          logic [NP-1:0] vw = {16{2'(sv)}};
          logic [NP-1:0] ew = {16{2'(se)}};
          set_ctl(32'h6E1D_B0A7, 32'hB5A3_7C18, vw, vw, ew, ew, o ? 32'hFF00_0FF0 : '0);
          check_pins(o ? "R7 R12 sweep" : "R6 R12 sweep");
        end

    // R5: per-pin distinct codes exercise field placement
    for (int m = 0; m < 3; m++) begin
      set_ctl(32'h5A5A_F00F, 32'h3C96_C369, mk_sel(0, m), mk_sel(1, m),
              mk_sel(0, (m+1)%3), mk_sel(1, (m+1)%3), m == 2 ? 32'h0F0F_0F0F : '0);
      check_pins("R5 field position");
    end

    // R8: synchronizer latency
    begin
      logic [NP-1:0] pats [4] = '{32'h0000_0001, 32'hDEAD_BEEF, 32'h8000_0000, 32'h0F0F_1234};
      logic [NP-1:0] prev = pin_in;
      for (int p = 0; p < 4; p++) begin
        pin_in = pats[p];
        rd(7, d); chk(d === flip(prev), "R8 first read old", d, flip(prev));
        rd(7, d); chk(d === flip(prev), "R8 second read old", d, flip(prev));
        rd(7, d); chk(d === flip(pats[p]), "R8 third read new", d, flip(pats[p]));
        prev = pats[p];
      end
    end

    // R9: level word ignores writes
    wr(7, ~pin_in);
    rd(7, d); chk(d === flip(pin_in), "R9 level unaffected", d, flip(pin_in));
    check_pins("R9 pins unaffected");

    done = 1;
    finish_run();
  end

endmodule